// File: doc/BRIEF.md
# Program Counter Sequencer with Vectored Interrupts

This block produces the instruction address for a small 8-bit microcontroller. A 12-bit program counter steps forward one word per executed instruction and can be loaded with a jump target. On a call it saves the return address in a six-level hardware return stack. It restores that address on a return or a return-from-interrupt. Software cannot see the stack or its pointer.

Three interrupt sources feed the block: an external pin, a timer 0 overflow and a timer 1 overflow. Each one latches a pending bit and has its own enable. The block takes an interrupt only when the global enable bit is set, the source is enabled and the stack has a free level. It then saves the address of the instruction that was about to run and jumps to a fixed vector for that source. It also gives a one-cycle acknowledge that carries the source code. An interrupt that cannot be taken stays pending until it can be taken.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the PC is 000H, the stack is empty (full flag low), the global enable is 0 and no acknowledge is shown.
- R2: With only the advance input high, the PC increases by one on the next clock and wraps from FFFH to 000H.
- R3: A jump loads the 12-bit target into the PC on the next clock and leaves the stack unchanged.
- R4: A call pushes PC+1 and loads the target. A later return or return-from-interrupt reloads the PC with the most recently pushed value.
- R5: When several control inputs are high in one cycle, return/return-from-interrupt wins over call, call over jump, and jump over advance.
- R6: A taken interrupt sets the PC to 004H for the external source (code 0), 008H for timer 0 (code 1) or 00CH for timer 1 (code 2). In that same cycle ack_o is high for one cycle and ack_src_o carries the code.
- R7: An interrupt is taken only when the global enable is 1, the source's enable is 1 and the stack holds fewer than 6 entries. Otherwise its request stays pending.
- R8: When more than one eligible source is pending, the external source is taken first, then timer 0, then timer 1.
- R9: Taking an interrupt clears the global enable and a return-from-interrupt sets it. A plain return leaves it unchanged. A software write sets it to gie_d_i unless an interrupt or return-from-interrupt acts in the same cycle.
- R10: An interrupt saves the current PC, which is the instruction not yet executed. The control inputs of that cycle are ignored.
- R11: The stack holds 6 entries and stk_full_o is high when all 6 are used. A call while full discards the oldest entry and keeps the other five.
- R12: A return with an empty stack loads 000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance to the next sequential address |
| jmp_i | input | 1 | Load PC with tgt_i |
| call_i | input | 1 | Push PC+1, load PC with tgt_i |
| tgt_i | input | 12 | Jump/call target |
| ret_i | input | 1 | Return from subroutine |
| reti_i | input | 1 | Return from interrupt |
| gie_wr_i | input | 1 | Software write of the global enable |
| gie_d_i | input | 1 | Value for the global enable write |
| irq_req_i | input | 3 | Request pulses: bit0 external, bit1 timer 0, bit2 timer 1 |
| irq_en_i | input | 3 | Per-source enables, same bit order |
| pc_o | output | 12 | Current program counter |
| stk_full_o | output | 1 | All stack levels used |
| gie_o | output | 1 | Global interrupt enable |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| ack_src_o | output | 2 | Code of the acknowledged source |

## Verification
The bench builds the block with its default parameters: a 12-bit PC, a 6-level stack and 3 sources. At this size a few calls fill the stack. The stack-full blocking of interrupts and the discard of the oldest entry therefore come up often under random stimulus. With a 12-bit PC, a directed jump to FFFH reaches the wrap point, and 1-in-16 request rates often leave several sources pending at once, which exercises the priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2
  } irq_src_e;

  // Vector base of source index n: (n + 1) << shift
  function automatic int unsigned vec_base(input int unsigned idx, input int unsigned shift);
    return (idx + 1) << shift;
  endfunction

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [W-1:0]  ent_q [DEPTH];
  logic [W-1:0]  ent_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ent_en, cnt_en;

  // Shift-register stack: index 0 is the top, the oldest entry falls off the bottom
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] from_above, from_below;
    if (i == 0) begin : g_top
      assign from_above = din_i;
    end else begin : g_mid
      assign from_above = ent_q[i-1];
    end
    if (i == DEPTH - 1) begin : g_bot
      assign from_below = '0;
    end else begin : g_up
      assign from_below = ent_q[i+1];
    end
    always_comb begin
      ent_d[i] = ent_q[i];
      if (push_i)     ent_d[i] = from_above;
      else if (pop_i) ent_d[i] = from_below;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= ent_d[i];
    end
  end

  assign ent_en = push_i | pop_i;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (push_i && cnt_q != DEPTH_C) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (pop_i && !push_i && cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign top_o  = ent_q[0];
  assign full_o = (cnt_q == DEPTH_C);

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);

  p_full_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (full_o && ent_q[0] == $past(din_i)));

  p_pop_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop_i && !push_i) |-> (top_o == '0));

endmodule

// File: rtl/pcseq_irq_arb.sv
module pcseq_irq_arb #(
  parameter int N     = 3,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  en_i,
  input  logic          gie_i,
  input  logic          blk_i,
  output logic          take_o,
  output logic [IW-1:0] sel_o
);

  logic [N-1:0] pend_q, pend_d, elig, grant, clr;

  assign elig = pend_q & en_i;

  // Fixed priority: lowest index wins
  always_comb begin
    sel_o = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel_o = IW'(i);
        grant = N'(1) << i;
      end
    end
  end

  assign take_o = gie_i & (|elig) & ~blk_i;
  assign clr    = take_o ? grant : '0;
  assign pend_d = (pend_q & ~clr) | req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_pend_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_taken_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (req_i & grant) == '0) |=> ((pend_q & $past(grant)) == '0));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int PC_W      = 12,
  parameter int STK_DEPTH = 6,
  parameter int N_IRQ     = 3,
  parameter int VEC_SHIFT = 2,
  localparam int SW       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            jmp_i,
  input  logic            call_i,
  input  logic [PC_W-1:0] tgt_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            gie_wr_i,
  input  logic            gie_d_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic [PC_W-1:0] pc_o,
  output logic            stk_full_o,
  output logic            gie_o,
  output logic            ack_o,
  output logic [SW-1:0]   ack_src_o
);

  import pcseq_pkg::*;

  logic [PC_W-1:0] pc_q, pc_d, pc_inc, stk_top, stk_din, vec_addr;
  logic            gie_q, gie_d, ack_q;
  logic [SW-1:0]   src_q, sel;
  logic            take, stk_full, push, pop, do_ret;

  pcseq_irq_arb #(.N(N_IRQ)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_req_i),
    .en_i   (irq_en_i),
    .gie_i  (gie_q),
    .blk_i  (stk_full),
    .take_o (take),
    .sel_o  (sel)
  );

  pcseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (stk_din),
    .top_o  (stk_top),
    .full_o (stk_full)
  );

  assign pc_inc   = pc_q + 1'b1;
  assign vec_addr = PC_W'(vec_base(32'(sel), VEC_SHIFT));
  assign do_ret   = ret_i | reti_i;
  assign push     = take | (call_i & ~do_ret);
  assign pop      = ~take & do_ret;
  assign stk_din  = take ? pc_q : pc_inc;

  // Next PC
  always_comb begin
    pc_d = pc_q;
    if (take)                pc_d = vec_addr;
    else if (do_ret)         pc_d = stk_top;
    else if (call_i | jmp_i) pc_d = tgt_i;
    else if (adv_i)          pc_d = pc_inc;
  end

  // Next global enable
  always_comb begin
    gie_d = gie_q;
    if (take)          gie_d = 1'b0;
    else if (reti_i)   gie_d = 1'b1;
    else if (gie_wr_i) gie_d = gie_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      gie_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      gie_q <= gie_d;
      ack_q <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    src_q <= '0;
    else if (take) src_q <= sel;
  end

  assign pc_o       = pc_q;
  assign stk_full_o = stk_full;
  assign gie_o      = gie_q;
  assign ack_o      = ack_q;
  assign ack_src_o  = src_q;

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (pc_q == PC_W'(vec_base(32'(src_q), VEC_SHIFT))));

  p_ack_clears_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !gie_q);

  p_reti_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && reti_i) |=> gie_q);

  p_ret_keeps_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && ret_i && !reti_i && !gie_wr_i) |=> (gie_q == $past(gie_q)));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && adv_i && !jmp_i && !call_i && !ret_i && !reti_i)
      |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));

  p_call_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && call_i && !ret_i && !reti_i) |=> (pc_q == $past(tgt_i)));

  p_irq_saves_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (u_stk.top_o == $past(pc_q)));

endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;

  localparam int D = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i, jmp_i, call_i, ret_i, reti_i, gie_wr_i, gie_d_i;
  logic [11:0] tgt_i;
  logic [2:0]  irq_req_i, irq_en_i;
  logic [11:0] pc_o;
  logic        stk_full_o, gie_o, ack_o;
  logic [1:0]  ack_src_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model state
  logic [11:0] m_st [D];
  int          m_cnt;
  logic [11:0] m_pc;
  logic        m_gie, m_ack;
  logic [1:0]  m_src;
  logic [2:0]  m_pend;
  string       m_tag;

  always #2.5 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jmp_i(jmp_i), .call_i(call_i),
    .tgt_i(tgt_i), .ret_i(ret_i), .reti_i(reti_i), .gie_wr_i(gie_wr_i),
    .gie_d_i(gie_d_i), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
    .pc_o(pc_o), .stk_full_o(stk_full_o), .gie_o(gie_o), .ack_o(ack_o),
    .ack_src_o(ack_src_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void m_push(input logic [11:0] v);
    for (int i = D - 1; i > 0; i--) m_st[i] = m_st[i-1];
    m_st[0] = v;
    if (m_cnt < D) m_cnt++;
  endfunction

  function automatic logic [11:0] m_pop();
    logic [11:0] v = m_st[0];
    for (int i = 0; i < D - 1; i++) m_st[i] = m_st[i+1];
    m_st[D-1] = '0;
    if (m_cnt > 0) m_cnt--;
    return v;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < D; i++) m_st[i] = '0;
    m_cnt = 0; m_pc = '0; m_gie = 0; m_ack = 0; m_src = '0; m_pend = '0;
  endfunction

  // One clock of the expected behaviour
  function automatic void m_step();
    logic [2:0] elig = m_pend & irq_en_i;
    logic       take = m_gie && elig != 0 && m_cnt < D;
    int         sel  = elig[0] ? 0 : elig[1] ? 1 : 2;
    int         nctl = int'(adv_i) + int'(jmp_i) + int'(call_i) + int'(ret_i | reti_i);
    logic [2:0] clr  = '0;
    m_tag = "R2 R3";
    if (take) begin
      m_tag = ($countones(elig) > 1) ? "R8 R10" : "R6 R10";
      m_push(m_pc);
      m_pc = 12'((sel + 1) * 4);
      m_gie = 0; m_ack = 1; m_src = 2'(sel);
      clr[sel] = 1'b1;
    end else begin
      m_ack = 0;
      if (elig != 0) m_tag = "R7";
      if (ret_i | reti_i) begin
        m_tag = (m_cnt == 0) ? "R12" : "R4";
        m_pc = m_pop();
      end else if (call_i) begin
        m_tag = (m_cnt == D) ? "R11" : "R4";
        m_push(m_pc + 12'd1);
        m_pc = tgt_i;
      end else if (jmp_i) m_pc = tgt_i;
      else if (adv_i)    m_pc = m_pc + 12'd1;
      if (nctl > 1) m_tag = "R5";
      if (reti_i) m_gie = 1;
      else if (gie_wr_i) m_gie = gie_d_i;
    end
    m_pend = (m_pend & ~clr) | irq_req_i;
  endfunction

  task automatic compare();
    chk(m_tag, pc_o, m_pc);
    chk("R11", stk_full_o, m_cnt == D);
    chk("R9", gie_o, m_gie);
    chk("R6", ack_o, m_ack);
    if (m_ack) chk("R6", ack_src_o, m_src);
  endtask

  task automatic idle_inputs();
    adv_i = 0; jmp_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    gie_wr_i = 0; gie_d_i = 0; tgt_i = '0; irq_req_i = '0;
  endtask

  // Inputs already set at a falling edge; clock once, check at next falling edge
  task automatic tick();
    m_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; irq_en_i = '0;
    idle_inputs();
    m_reset();
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1", pc_o, 0); chk("R1", stk_full_o, 0); chk("R1", gie_o, 0); chk("R1", ack_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pc_o, 0); chk("R1", gie_o, 0);

    // R2: wrap at FFFH
    jmp_i = 1; tgt_i = 12'hFFF; tick();
    adv_i = 1; tick();
    chk("R2", pc_o, 0);

    // R12: return with empty stack
    jmp_i = 1; tgt_i = 12'h345; tick();
    ret_i = 1; tick();
    chk("R12", pc_o, 0);

    // R11: seven calls, then seven returns (oldest entry dropped)
    for (int k = 0; k < 7; k++) begin
      call_i = 1; tgt_i = 12'(12'h100 + k * 16); tick();
    end
    chk("R11", stk_full_o, 1);
    for (int k = 0; k < 7; k++) begin
      ret_i = 1; tick();
    end
    chk("R12", pc_o, 0);

    // R7/R8: full stack blocks all three pending sources
    for (int k = 0; k < 6; k++) begin
      call_i = 1; tgt_i = 12'(12'h200 + k); tick();
    end
    irq_en_i = 3'b111; gie_wr_i = 1; gie_d_i = 1; irq_req_i = 3'b111; tick();
    adv_i = 1; tick();
    chk("R7", ack_o, 0);
    ret_i = 1; tick();
    adv_i = 1; call_i = 1; tgt_i = 12'h777; tick();   // R10: ignored control
    chk("R8", ack_src_o, 0);
    chk("R6", pc_o, 12'h004);
    reti_i = 1; tick();
    chk("R9", gie_o, 1);
    adv_i = 1; tick();
    chk("R8", ack_src_o, 1);
    chk("R6", pc_o, 12'h008);

    // R5: simultaneous control inputs
    reti_i = 1; call_i = 1; jmp_i = 1; adv_i = 1; tgt_i = 12'h0AA; tick();
    tick();
    chk("R8", ack_src_o, 2);
    chk("R6", pc_o, 12'h00C);

    // Constrained random phase
    for (int c = 0; c < 4000; c++) begin
      adv_i    = ($urandom % 4) != 0;
      jmp_i    = ($urandom % 10) == 0;
      call_i   = ($urandom % 7) == 0;
      ret_i    = ($urandom % 8) == 0;
      reti_i   = ($urandom % 20) == 0;
      gie_wr_i = ($urandom % 12) == 0;
      gie_d_i  = ($urandom % 3) != 0;
      tgt_i    = (($urandom % 16) == 0) ? 12'hFFF : 12'($urandom);
      for (int s = 0; s < 3; s++) irq_req_i[s] = ($urandom % 16) == 0;
      if (($urandom % 50) == 0) irq_en_i = 3'($urandom);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule